// File: doc/BRIEF.md
# Interrupt Source PQ State Controller

This block keeps a two-bit coalescing state for each source in a bank of interrupt sources. A bit P marks a source whose notice has gone to the router and still waits for an end-of-interrupt. A bit Q records that the source fired again in the meantime. Because of this, a source appears at most once in a downstream queue. The sources fire from input lines or from software. Each firing that the state lets through produces a notice carrying the source number. The notices go out on a valid/ready strobe toward a routing stage.

Software reaches the state through a load/store port. The upper address bits select the page of a source, and the offset inside that page selects an operation. Every load returns the state held before the access and applies its update in the same cycle. Pages can be laid out in two ways. In the single-page layout, one page serves both triggering and management. In the split layout, the lower half of each page triggers and the upper half holds the management operations.

Each source is either edge-triggered or level-sensitive, chosen by a configuration mask. A level-sensitive source keeps firing at end-of-interrupt for as long as its line stays asserted.

Top module: `irq_pq_ctrl`

## Requirements
- R1: After reset every source holds PQ = 00, `ntf_valid` is low and `rsp_valid` is low.
- R2: The state encoding is P = bit 1 and Q = bit 0. A trigger moves the state as follows. From 00 it goes to 10 and emits one notice. From 10 or 11 it goes to 11 with no notice. From 01 (off) the trigger is dropped and the state stays 01. A trigger is either a store to the trigger page or a rising edge on the line of an edge-type source.
- R3: An end-of-interrupt is a load at management offset 0x000, or a store at offset 0x400 when `store_eoi_en` is high. For an edge-type source it works as follows. From 11 it goes to 10 and emits a notice. From 10 or 00 it goes to 00. From 01 the state stays 01 with no notice. A load EOI returns the state held before the access.
- R4: A load at offset 0x800 returns the state and leaves it unchanged. Loads at 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 with no notice, and return the old state. Load data carries PQ in bits [1:0] with all other bits zero. `rsp_valid` pulses exactly one cycle after each load request and never after a store.
- R5: With `store_eoi_en` low, a store at offset 0x400 leaves the state unchanged and emits no notice.
- R6: The source number is `req_addr >> PAGE_SHIFT`. With `PAGE_SHIFT` 13 or 17 the layout is split: address bit `PAGE_SHIFT-1` = 1 selects the management half, and any store to the lower half triggers. With `PAGE_SHIFT` 12 or 16 the layout is single-page: a store at offset 0 triggers and a load at offset 0 is a load EOI.
- R7: A load at any other offset, or a load in the trigger half, returns zero and changes no state. A store at an offset other than those above is ignored.
- R8: For a source whose `lsi_mask` bit is 1, an asserted line in state 00 moves the state to 10 and emits a notice. At end-of-interrupt the source goes to 10 with a notice if the line is still asserted, and to 00 otherwise, whatever Q holds. State 01 stays 01.
- R9: When a bus operation and a line trigger hit the same source in the same cycle, the bus operation is applied first and the trigger is applied to its result. A load returns the state held before both.
- R10: Notices waiting for the router are issued lowest source number first. `ntf_src` stays stable while `ntf_valid` is high and `ntf_ready` is low, and no notice is lost while the router stalls.
- R11: An edge-type line fires only on its rising edge. A line held high produces no further notice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | SRC_W+PAGE_SHIFT | Byte address inside the source window |
| rsp_valid | output | 1 | Load data valid (one cycle after the load) |
| rsp_data | output | DATA_W | Old PQ in bits [1:0], zeros above |
| store_eoi_en | input | 1 | Enables end-of-interrupt by store at 0x400 |
| lsi_mask | input | NUM_SRC | 1 = level-sensitive source |
| irq_in | input | NUM_SRC | Interrupt input lines |
| ntf_valid | output | 1 | A notice is offered to the router |
| ntf_ready | input | 1 | Router accepts the notice |
| ntf_src | output | SRC_W | Source number of the offered notice |

## Verification
Two functions can fall in the same cycle on one source. One is a bus operation, for example a load EOI on a source in state 11. The other is a rising edge on that source's line. The bench raises the line one cycle before it issues the load, so the synchronised edge and the request reach the state in the same clock. It then judges the loaded value (the state before both), the follow-up state read with load get (11), and the number of notices (exactly one).

The second overlap is several sources firing in one cycle while the router stalls. The bench checks that the first notice offered is the lowest source number and that it holds steady during the stall. After the stall ends, the notices must drain in source order.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_LD_EOI,
    OP_ST_EOI,
    OP_GET,
    OP_SET,
    OP_RDZ
  } op_e;

  localparam logic [31:0] OFS_LD_EOI = 32'h000;
  localparam logic [31:0] OFS_ST_EOI = 32'h400;
  localparam logic [31:0] OFS_GET    = 32'h800;

  // returns {notify, next_state}
  function automatic logic [2:0] pq_trigger(input logic [1:0] s);
    case (s)
      2'b00:   pq_trigger = {1'b1, 2'b10};
      2'b01:   pq_trigger = {1'b0, 2'b01};
      default: pq_trigger = {1'b0, 2'b11};
    endcase
  endfunction

  function automatic logic [2:0] pq_eoi(input logic [1:0] s, input logic lsi,
                                        input logic lvl);
    if (s == 2'b01)      pq_eoi = {1'b0, 2'b01};
    else if (lsi)        pq_eoi = lvl ? {1'b1, 2'b10} : {1'b0, 2'b00};
    else if (s == 2'b11) pq_eoi = {1'b1, 2'b10};
    else                 pq_eoi = {1'b0, 2'b00};
  endfunction

endpackage

// File: rtl/irq_pq_decode.sv
module irq_pq_decode
  import irq_pq_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int PAGE_SHIFT = 13,
  parameter int SRC_W      = 3,
  parameter int ADDR_W     = 16
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              store_eoi_en,
  output op_e               op,
  output logic [SRC_W-1:0]  op_src,
  output logic [1:0]        op_val
);

  localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);
  localparam int OFF_W    = TWO_PAGE ? PAGE_SHIFT - 1 : PAGE_SHIFT;

  logic        mgmt;
  logic [31:0] off32;
  logic        src_ok;
  logic        set_hit;

  generate
    if (TWO_PAGE) begin : g_split
      assign mgmt = req_addr[PAGE_SHIFT-1];
    end else begin : g_single
      assign mgmt = 1'b1;
    end
  endgenerate

  assign off32   = 32'(req_addr[OFF_W-1:0]);
  assign op_src  = req_addr[PAGE_SHIFT +: SRC_W];
  assign src_ok  = 32'(op_src) < 32'(NUM_SRC);
  assign op_val  = off32[9:8];
  assign set_hit = (off32[31:12] == 20'd0) && (off32[11:10] == 2'b11) &&
                   (off32[7:0] == 8'd0);

  always_comb begin
    op = OP_NONE;
    if (req_valid) begin
      if (!src_ok) begin
        op = req_write ? OP_NONE : OP_RDZ;
      end else if (req_write) begin
        if (!mgmt)                          op = OP_TRIG;
        else if (!TWO_PAGE && off32 == 32'd0) op = OP_TRIG;
        else if (off32 == OFS_ST_EOI && store_eoi_en) op = OP_ST_EOI;
        else                                op = OP_NONE;
      end else begin
        if (!mgmt)                     op = OP_RDZ;
        else if (off32 == OFS_LD_EOI)  op = OP_LD_EOI;
        else if (off32 == OFS_GET)     op = OP_GET;
        else if (set_hit)              op = OP_SET;
        else                           op = OP_RDZ;
      end
    end
  end

endmodule

// File: rtl/irq_pq_bank.sv
module irq_pq_bank
  import irq_pq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  op_e                op,
  input  logic [SRC_W-1:0]   op_src,
  input  logic [1:0]         op_val,
  input  logic [NUM_SRC-1:0] lsi_mask,
  input  logic [NUM_SRC-1:0] line_lvl,
  input  logic [NUM_SRC-1:0] line_edge,
  output logic [1:0]         old_pq,
  output logic [NUM_SRC-1:0] ntf_vec
);

  logic [1:0] pq_q [NUM_SRC];

  assign old_pq = pq_q[op_src];

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic       hit;
      logic [1:0] s1, s2;
      logic       n1, n2;

      assign hit = (op != OP_NONE) && (op_src == SRC_W'(i));

      always_comb begin
        s1 = pq_q[i];
        n1 = 1'b0;
        if (hit) begin
          case (op)
            OP_TRIG:              {n1, s1} = pq_trigger(pq_q[i]);
            OP_LD_EOI, OP_ST_EOI: {n1, s1} = pq_eoi(pq_q[i], lsi_mask[i], line_lvl[i]);
            OP_SET:               s1 = op_val;
            default:              s1 = pq_q[i];
          endcase
        end
      end

      always_comb begin
        s2 = s1;
        n2 = 1'b0;
        if (lsi_mask[i]) begin
          if (line_lvl[i] && s1 == 2'b00) begin
            s2 = 2'b10;
            n2 = 1'b1;
          end
        end else if (line_edge[i]) begin
          {n2, s2} = pq_trigger(s1);
        end
      end

      assign ntf_vec[i] = n1 | n2;

      always_ff @(posedge clk) begin
        if (rst) pq_q[i] <= 2'b00;
        else     pq_q[i] <= s2;
      end

      // R2: a source that just notified is left pending
      assert_notify_pending_R2: assert property (@(posedge clk) disable iff (rst)
        ntf_vec[i] |=> pq_q[i][1]);

      // R2: an off source stays off unless software touches it
      assert_off_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (pq_q[i] == 2'b01 && !hit) |=> pq_q[i] == 2'b01);
    end
  endgenerate

endmodule

// File: rtl/irq_pq_notify.sv
module irq_pq_notify #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ntf_vec,
  input  logic               ntf_ready,
  output logic               ntf_valid,
  output logic [SRC_W-1:0]   ntf_src
);

  logic [NUM_SRC-1:0] pend_q, pend_n;
  logic [SRC_W-1:0]   pick;
  logic               any;
  logic               slot_free;

  assign slot_free = !ntf_valid || ntf_ready;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int j = NUM_SRC - 1; j >= 0; j--) begin
      if (pend_q[j]) begin
        pick = SRC_W'(j);
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    pend_n = pend_q;
    if (slot_free && any) pend_n[pick] = 1'b0;
    pend_n = pend_n | ntf_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      ntf_valid <= 1'b0;
      ntf_src   <= '0;
    end else begin
      pend_q <= pend_n;
      if (slot_free) begin
        ntf_valid <= any;
        if (any) ntf_src <= pick;
      end
    end
  end

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_src)));

  assert_src_range_R10: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> (32'(ntf_src) < 32'(NUM_SRC)));

endmodule

// File: rtl/irq_pq_ctrl.sv
module irq_pq_ctrl
  import irq_pq_pkg::*;
#(
  parameter int  NUM_SRC    = 8,
  parameter int  PAGE_SHIFT = 13,
  parameter int  DATA_W     = 64,
  localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W     = SRC_W + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic               store_eoi_en,
  input  logic [NUM_SRC-1:0] lsi_mask,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               ntf_valid,
  input  logic               ntf_ready,
  output logic [SRC_W-1:0]   ntf_src
);

  op_e                op;
  logic [SRC_W-1:0]   op_src;
  logic [1:0]         op_val;
  logic [1:0]         old_pq;
  logic [NUM_SRC-1:0] ntf_vec;
  logic [NUM_SRC-1:0] line_s, line_p;
  logic [NUM_SRC-1:0] line_lvl, line_edge;
  logic               ret_state;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_s <= '0;
      line_p <= '0;
    end else begin
      line_s <= irq_in;
      line_p <= line_s;
    end
  end

  assign line_lvl  = line_s & lsi_mask;
  assign line_edge = line_s & ~line_p & ~lsi_mask;

  irq_pq_decode #(
    .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) i_decode (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .store_eoi_en(store_eoi_en), .op(op), .op_src(op_src), .op_val(op_val)
  );

  irq_pq_bank #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_bank (
    .clk(clk), .rst(rst), .op(op), .op_src(op_src), .op_val(op_val),
    .lsi_mask(lsi_mask), .line_lvl(line_lvl), .line_edge(line_edge),
    .old_pq(old_pq), .ntf_vec(ntf_vec)
  );

  irq_pq_notify #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_notify (
    .clk(clk), .rst(rst), .ntf_vec(ntf_vec), .ntf_ready(ntf_ready),
    .ntf_valid(ntf_valid), .ntf_src(ntf_src)
  );

  assign ret_state = (op == OP_LD_EOI) || (op == OP_GET) || (op == OP_SET);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_data  <= ret_state ? {{(DATA_W-2){1'b0}}, old_pq} : '0;
    end
  end

  assert_rsp_after_load_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_rsp_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_data[DATA_W-1:2] == '0));

endmodule

// File: tb/test_irq_pq_ctrl.sv
module test_irq_pq_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        store_eoi_en = 0;
  logic [7:0]  lsi_mask = 8'hC0;
  logic [7:0]  irq_in = '0;
  logic        ntf_valid, ntf_ready = 1;
  logic [2:0]  ntf_src;

  logic        c_valid = 0, c_write = 0;
  logic [14:0] c_addr = '0;
  logic        c_rsp_valid;
  logic [63:0] c_rsp_data;
  logic        c_ntf_valid;
  logic [2:0]  c_ntf_src;

  always #4 clk = ~clk;

  irq_pq_ctrl i_irq_pq_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .store_eoi_en(store_eoi_en), .lsi_mask(lsi_mask), .irq_in(irq_in),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_src(ntf_src)
  );

  irq_pq_ctrl #(.PAGE_SHIFT(12)) i_irq_pq_ctrl_1p (
    .clk(clk), .rst(rst), .req_valid(c_valid), .req_write(c_write),
    .req_addr(c_addr), .rsp_valid(c_rsp_valid), .rsp_data(c_rsp_data),
    .store_eoi_en(1'b1), .lsi_mask(8'h00), .irq_in(8'h00),
    .ntf_valid(c_ntf_valid), .ntf_ready(1'b1), .ntf_src(c_ntf_src)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int ntf_cnt [8];
  int exp_cnt [8];
  logic [1:0] exp_pq [8];
  int log_src [256];
  int log_len = 0;

  always @(negedge clk) begin
    if (!rst && ntf_valid && ntf_ready) begin
      ntf_cnt[ntf_src] = ntf_cnt[ntf_src] + 1;
      if (log_len < 256) log_src[log_len] = int'(ntf_src);
      log_len = log_len + 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ma(int s, int off);
    return 16'((s << 13) | (1 << 12) | off);
  endfunction
  function automatic logic [15:0] ta(int s);
    return 16'(s << 13);
  endfunction

  task automatic mdl_trig(int s);
    case (exp_pq[s])
      2'b00: begin exp_pq[s] = 2'b10; exp_cnt[s]++; end
      2'b01: ;
      default: exp_pq[s] = 2'b11;
    endcase
  endtask

  task automatic mdl_eoi(int s, bit lsi, bit lvl);
    if (exp_pq[s] == 2'b01) ;
    else if (lsi) begin
      if (lvl) begin exp_pq[s] = 2'b10; exp_cnt[s]++; end
      else exp_pq[s] = 2'b00;
    end else if (exp_pq[s] == 2'b11) begin
      exp_pq[s] = 2'b10; exp_cnt[s]++;
    end else exp_pq[s] = 2'b00;
  endtask

  task automatic bus(input bit sel, input logic wr, input logic [15:0] addr,
                     output logic [63:0] data, output logic got);
    @(posedge clk); #1;
    if (sel) begin c_valid = 1; c_write = wr; c_addr = addr[14:0]; end
    else begin req_valid = 1; req_write = wr; req_addr = addr; end
    @(posedge clk); #1;
    c_valid = 0; req_valid = 0;
    got  = sel ? c_rsp_valid : rsp_valid;
    data = sel ? c_rsp_data : rsp_data;
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic ld(input string tag, input logic [15:0] addr, input longint exp);
    logic [63:0] d; logic g;
    bus(0, 0, addr, d, g);
    chk({tag, " rsp_valid"}, g, 1);
    chk(tag, d, exp);
  endtask

  task automatic st(input logic [15:0] addr);
    logic [63:0] d; logic g;
    bus(0, 1, addr, d, g);
  endtask

  task automatic chk_cnt(input string tag, int s);
    chk(tag, ntf_cnt[s], exp_cnt[s]);
  endtask

  task automatic line_pulse(int s);
    @(posedge clk); #1 irq_in[s] = 1;
    repeat (3) @(posedge clk);
    #1 irq_in[s] = 0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d; logic g;
    logic [1:0] r;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++) begin
      ntf_cnt[i] = 0; exp_cnt[i] = 0; exp_pq[i] = 2'b00;
    end
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #1;
    chk("R1 ntf_valid after reset", ntf_valid, 0);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    for (int i = 0; i < 8; i++) ld("R1 reset state get", ma(i, 'h800), 0);

    // R2 software trigger on idle, then again
    st(ta(0)); mdl_trig(0);
    ld("R2 trigger idle -> 10", ma(0, 'h800), 2);
    chk_cnt("R2 one notice", 0);
    st(ta(0) | 16'h0108); mdl_trig(0);
    ld("R2 trigger pending -> 11", ma(0, 'h800), 3);
    chk_cnt("R2 no extra notice", 0);

    // R3 load EOI
    ld("R3 load EOI returns 11", ma(0, 'h000), 3); mdl_eoi(0, 0, 0);
    chk_cnt("R3 EOI with Q notifies", 0);
    ld("R3 state after EOI", ma(0, 'h800), 2);
    ld("R3 load EOI returns 10", ma(0, 'h000), 2); mdl_eoi(0, 0, 0);
    ld("R3 back to idle", ma(0, 'h800), 0);
    chk_cnt("R3 no notice without Q", 0);

    // R4 set ops and off state
    ld("R4 set 01 returns old", ma(0, 'hD00), 0); exp_pq[0] = 2'b01;
    st(ta(0)); mdl_trig(0);
    ld("R2 trigger dropped when off", ma(0, 'h800), 1);
    ld("R3 EOI on off returns 01", ma(0, 'h000), 1); mdl_eoi(0, 0, 0);
    ld("R3 off stays off", ma(0, 'h800), 1);
    chk_cnt("R2 off never notifies", 0);
    ld("R4 set 10 returns 01", ma(0, 'hE00), 1); exp_pq[0] = 2'b10;
    ld("R4 set 11 returns 10", ma(0, 'hF00), 2); exp_pq[0] = 2'b11;
    chk_cnt("R4 set gives no notice", 0);

    // R5 store EOI disabled, then enabled
    st(ma(0, 'h400));
    ld("R5 store EOI disabled no change", ma(0, 'h800), 3);
    chk_cnt("R5 no notice", 0);
    store_eoi_en = 1;
    st(ma(0, 'h400)); mdl_eoi(0, 0, 0);
    ld("R3 store EOI enabled", ma(0, 'h800), 2);
    chk_cnt("R3 store EOI notice", 0);

    // R7 unmapped offsets
    ld("R7 unmapped load reads zero", ma(0, 'h100), 0);
    ld("R7 trigger-half load reads zero", ta(0) | 16'h0800, 0);
    st(ma(0, 'h800));
    st(ma(0, 'hC00));
    ld("R7 state untouched", ma(0, 'h800), 2);
    chk_cnt("R7 no notice", 0);

    // R11 edge line
    @(posedge clk); #1 irq_in[1] = 1; mdl_trig(1);
    repeat (12) @(posedge clk); #1;
    chk_cnt("R11 rising edge notifies once", 1);
    ld("R11 state pending", ma(1, 'h800), 2);
    ld("R11 EOI", ma(1, 'h000), 2); mdl_eoi(1, 0, 0);
    repeat (6) @(posedge clk); #1;
    ld("R11 held line no retrigger", ma(1, 'h800), 0);
    chk_cnt("R11 held line no notice", 1);
    #1 irq_in[1] = 0;
    repeat (3) @(posedge clk);
    line_pulse(1); mdl_trig(1);
    chk_cnt("R11 new edge notifies", 1);

    // R8 level source 6
    @(posedge clk); #1 irq_in[6] = 1;
    exp_pq[6] = 2'b10; exp_cnt[6]++;
    repeat (8) @(posedge clk); #1;
    chk_cnt("R8 level notifies", 6);
    ld("R8 level pending", ma(6, 'h800), 2);
    chk_cnt("R8 level held no repeat", 6);
    ld("R8 EOI with line high", ma(6, 'h000), 2); mdl_eoi(6, 1, 1);
    chk_cnt("R8 EOI re-notifies", 6);
    ld("R8 still pending", ma(6, 'h800), 2);
    @(posedge clk); #1 irq_in[6] = 0;
    repeat (4) @(posedge clk); #1;
    ld("R8 set 11 with line low", ma(6, 'hF00), 2); exp_pq[6] = 2'b11;
    ld("R8 EOI line low", ma(6, 'h000), 3); mdl_eoi(6, 1, 0);
    ld("R8 Q ignored -> 00", ma(6, 'h800), 0);
    chk_cnt("R8 no notice line low", 6);

    // R9 same-cycle bus EOI and line edge on source 2
    ld("R9 set 11", ma(2, 'hF00), 0); exp_pq[2] = 2'b11;
    @(posedge clk); #1 irq_in[2] = 1;
    @(posedge clk); #1 req_valid = 1; req_write = 0; req_addr = ma(2, 'h000);
    @(posedge clk); #1 req_valid = 0;
    chk("R9 load returns state before both", rsp_data, 3);
    mdl_eoi(2, 0, 0); mdl_trig(2);
    repeat (6) @(posedge clk); #1 irq_in[2] = 0;
    ld("R9 EOI then trigger -> 11", ma(2, 'h800), 3);
    chk_cnt("R9 exactly one notice", 2);

    // R10 stall with three simultaneous sources
    @(posedge clk); #1 ntf_ready = 0; irq_in[5] = 1; irq_in[4] = 1; irq_in[3] = 1;
    for (int s = 3; s <= 5; s++) mdl_trig(s);
    repeat (5) @(posedge clk); #1;
    chk("R10 valid during stall", ntf_valid, 1);
    chk("R10 lowest source first", ntf_src, 3);
    repeat (4) @(posedge clk); #1;
    chk("R10 source stable while stalled", ntf_src, 3);
    irq_in[5:3] = 3'b000;
    begin
      int base; base = log_len;
      ntf_ready = 1;
      repeat (8) @(posedge clk); #1;
      chk("R10 drained count", log_len - base, 3);
      chk("R10 order 1st", log_src[base], 3);
      chk("R10 order 2nd", log_src[base+1], 4);
      chk("R10 order 3rd", log_src[base+2], 5);
    end

    // R6 single-page layout instance
    bus(1, 1, 16'((1 << 12) | 0), d, g);
    bus(1, 0, 16'((1 << 12) | 'h800), d, g);
    chk("R6 single-page store at 0 triggers", d, 2);
    bus(1, 0, 16'((1 << 12) | 0), d, g);
    chk("R6 single-page load at 0 is EOI", d, 2);
    bus(1, 0, 16'((1 << 12) | 'h800), d, g);
    chk("R6 single-page idle after EOI", d, 0);
    ld("R6 split source 1 unaffected by other instance", ma(1, 'h800), exp_pq[1]);

    // random phase on edge sources 0..5
    for (int it = 0; it < 300; it++) begin
      int s, k;
      s = $urandom_range(0, 5);
      k = $urandom_range(0, 5);
      case (k)
        0: begin st(ta(s) | 16'(($urandom_range(0, 15)) << 3)); mdl_trig(s); end
        1: begin ld("R3 random load EOI", ma(s, 'h000), exp_pq[s]); mdl_eoi(s, 0, 0); end
        2: begin st(ma(s, 'h400)); mdl_eoi(s, 0, 0); end
        3: ld("R4 random get", ma(s, 'h800), exp_pq[s]);
        4: begin
          r = 2'($urandom_range(0, 3));
          ld("R4 random set", ma(s, 'hC00 | (int'(r) << 8)), exp_pq[s]);
          exp_pq[s] = r;
        end
        default: begin line_pulse(s); mdl_trig(s); end
      endcase
    end
    repeat (8) @(posedge clk); #1;
    for (int s = 0; s < 8; s++) begin
      chk("R2 random notice count", ntf_cnt[s], exp_cnt[s]);
      ld("R3 random final state", ma(s, 'h800), exp_pq[s]);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule